// File: doc/BRIEF.md
# Partial-Word Merge Unit

This block executes the four partial-word instructions of a big-endian 32-bit core: load-left, load-right, store-left and store-right. Each instruction names a byte address. The block reads the aligned word that contains that byte. It then merges the word with a register operand, using lane masks and shift amounts chosen by the two low address bits.

A load merges the memory word into the old value of the target register. That old value is taken from the pending delayed-load slot when the slot holds the same register; otherwise it is the register-file value. The merged load result is handed back on a result port so the core can place it in its own load-delay slot. A result whose target is register 0 is dropped.

A store is a read-modify-write of the aligned word. The unit reads the word, merges the register value into it, writes the merged word back to the same address, and then pulses `done`. The core supplies one instruction at a time through a valid strobe. The memory side is a simple request/acknowledge port.

Top module: `partial_word_merge`

## Requirements
- R1: Every memory request addresses the aligned word: the request address equals the instruction address with its two low bits cleared. A store writes back to the same address it read.
- R2: Load-left (kind 2'b00), with o = address bits [1:0], returns (mem << (3-o)*8) | (old & m), where m is 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0 for o = 0, 1, 2, 3.
- R3: Load-right (kind 2'b01) returns (mem >> o*8) | (old & m), where m is 0, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 for o = 0, 1, 2, 3.
- R4: Store-left (kind 2'b10) writes (reg >> (3-o)*8) | (mem & m), where m is 0xFFFFFF00, 0xFFFF0000, 0xFF000000 or 0 for o = 0, 1, 2, 3.
- R5: Store-right (kind 2'b11) writes (reg << o*8) | (mem & m), where m is 0, 0x000000FF, 0x0000FFFF or 0x00FFFFFF for o = 0, 1, 2, 3.
- R6: For a load, the old register value is `pend_value` when `pend_valid` is high and `pend_reg` equals the target register; otherwise it is `rf_value`. A store always merges `rf_value`.
- R7: A store issues exactly one read (`mem_we` low) and then exactly one write (`mem_we` high). `done` pulses for one cycle in the cycle after the write is acknowledged. A load issues exactly one read and no write, and `done` pulses in the cycle after the read is acknowledged.
- R8: A load result is presented with `ld_valid` high in the same cycle as `done`. When the target register is 0, `ld_valid` stays low while `done` still pulses.
- R9: `op_valid` is ignored while `busy` is high. An instruction presented during an operation has no effect on that operation's result, and it causes no memory request.
- R10: After reset, `busy`, `mem_req`, `done` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Instruction strobe, accepted when idle |
| op_kind | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| op_addr | input | AW | Byte address of the access |
| op_reg | input | RW | Register operand index (load target or store source) |
| rf_value | input | 32 | Register-file value of `op_reg` |
| pend_valid | input | 1 | Delayed-load slot holds a value |
| pend_reg | input | RW | Register targeted by the delayed-load slot |
| pend_value | input | 32 | Value held in the delayed-load slot |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Aligned word address |
| mem_wdata | output | 32 | Merged word to write |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_valid | output | 1 | Load result valid for the delay slot |
| ld_reg | output | RW | Load result register |
| ld_value | output | 32 | Merged load value |

## Verification
The assertions check the handshake shape on every cycle:
- every operation starts with a read;
- a write only follows an acknowledged read, at the same address;
- `done` is a single-cycle pulse;
- a load result never names register 0;
- a new operation starts only from an accepted strobe.

The lane arithmetic of all four kinds at every offset can only be shown by the bench scenarios, which compare returned and written words against an independent model. The same holds for the choice between pending and register-file values, and for the absence of effect of a strobe that arrives while busy.

// File: rtl/partial_word_merge.sv
module partial_word_merge #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [RW-1:0] op_reg,
  input  logic [31:0]   rf_value,
  input  logic          pend_valid,
  input  logic [RW-1:0] pend_reg,
  input  logic [31:0]   pend_value,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          done,
  output logic          ld_valid,
  output logic [RW-1:0] ld_reg,
  output logic [31:0]   ld_value
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;

  state_t        st;
  logic [1:0]    kind_q;
  logic [1:0]    off_q;
  logic [AW-3:0] word_q;
  logic [RW-1:0] reg_q;
  logic [31:0]   opnd_q;
  logic [31:0]   mword_q;

  function automatic logic [31:0] merge(input logic [1:0] k, input logic [1:0] o,
                                        input logic [31:0] m, input logic [31:0] r);
    logic [4:0] lo;
    logic [4:0] hi;
    lo = {o, 3'b000};
    hi = {~o, 3'b000};
    case (k)
      2'b00:   merge = (m << hi) | (r & (32'h00FF_FFFF >> lo));
      2'b01:   merge = (m >> lo) | (r & ~(32'hFFFF_FFFF >> lo));
      2'b10:   merge = (r >> hi) | (m & ~(32'hFFFF_FFFF >> hi));
      default: merge = (r << lo) | (m & ~(32'hFFFF_FFFF << lo));
    endcase
  endfunction

  logic        fwd_hit;
  logic [31:0] ld_merged;

  assign fwd_hit   = !op_kind[1] && pend_valid && (pend_reg == op_reg);
  assign ld_merged = merge(kind_q, off_q, mem_rdata, opnd_q);

  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == S_WR);
  assign mem_addr  = {word_q, 2'b00};
  assign mem_wdata = merge(kind_q, off_q, mword_q, opnd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= '0;
      off_q    <= '0;
      word_q   <= '0;
      reg_q    <= '0;
      opnd_q   <= '0;
      mword_q  <= '0;
      done     <= 1'b0;
      ld_valid <= 1'b0;
      ld_reg   <= '0;
      ld_value <= '0;
    end else begin
      done     <= 1'b0;
      ld_valid <= 1'b0;
      case (st)
        S_IDLE: if (op_valid) begin
          kind_q <= op_kind;
          off_q  <= op_addr[1:0];
          word_q <= op_addr[AW-1:2];
          reg_q  <= op_reg;
          opnd_q <= fwd_hit ? pend_value : rf_value;
          st     <= S_RD;
        end
        S_RD: if (mem_ack) begin
          if (kind_q[1]) begin
            mword_q <= mem_rdata;
            st      <= S_WR;
          end else begin
            ld_valid <= (reg_q != '0);
            ld_reg   <= reg_q;
            ld_value <= ld_merged;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_WR: if (mem_ack) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !mem_we);

  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

  p_same_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> mem_addr == $past(mem_addr));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_reg0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (ld_reg != '0) && done);

  p_load_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !$past(mem_we));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_valid));

endmodule

// File: tb/partial_word_merge_tb.sv
module partial_word_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [31:0] op_addr = '0;
  logic [4:0]  op_reg = '0;
  logic [31:0] rf_value = '0;
  logic        pend_valid = 1'b0;
  logic [4:0]  pend_reg = '0;
  logic [31:0] pend_value = '0;
  logic        mem_req, mem_we, busy, done, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_value;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [4:0]  ld_reg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  partial_word_merge u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_reg(op_reg), .rf_value(rf_value), .pend_valid(pend_valid), .pend_reg(pend_reg),
    .pend_value(pend_value), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
    .done(done), .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_value(ld_value));

  logic [31:0] memword = '0;
  int          rd_cnt = 0, wr_cnt = 0, lat = 0, wr_before_rd = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = memword;
          if (mem_we) begin
            wr_cnt++; wr_addr = mem_addr; wr_data = mem_wdata;
          end else begin
            rd_cnt++; rd_addr = mem_addr;
          end
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  function automatic logic [31:0] ref_merge(input logic [1:0] k, input logic [1:0] o,
                                            input logic [31:0] m, input logic [31:0] r);
    logic [31:0] msk;
    case (k)
      2'b00: begin
        case (o) 2'd0: msk = 32'h00FFFFFF; 2'd1: msk = 32'h0000FFFF;
                 2'd2: msk = 32'h000000FF; default: msk = 32'h0; endcase
        return (m << (8 * (3 - o))) | (r & msk);
      end
      2'b01: begin
        case (o) 2'd0: msk = 32'h0; 2'd1: msk = 32'hFF000000;
                 2'd2: msk = 32'hFFFF0000; default: msk = 32'hFFFFFF00; endcase
        return (m >> (8 * o)) | (r & msk);
      end
      2'b10: begin
        case (o) 2'd0: msk = 32'hFFFFFF00; 2'd1: msk = 32'hFFFF0000;
                 2'd2: msk = 32'hFF000000; default: msk = 32'h0; endcase
        return (r >> (8 * (3 - o))) | (m & msk);
      end
      default: begin
        case (o) 2'd0: msk = 32'h0; 2'd1: msk = 32'h000000FF;
                 2'd2: msk = 32'h0000FFFF; default: msk = 32'h00FFFFFF; endcase
        return (r << (8 * o)) | (m & msk);
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  logic        g_ldv;
  logic [4:0]  g_reg;
  logic [31:0] g_val;
  int          d_rd, d_wr;
  logic        g_done;

  task automatic do_op(input logic [1:0] k, input logic [31:0] a, input logic [4:0] r,
                       input logic [31:0] rf, input logic pv, input logic [4:0] pr,
                       input logic [31:0] pval, input logic [31:0] m, input logic intrude);
    int r0, w0;
    memword = m;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_reg = r; rf_value = rf;
    pend_valid = pv; pend_reg = pr; pend_value = pval;
    @(negedge clk);
    if (intrude) begin
      op_kind = ~k; op_addr = a ^ 32'h0000_0F07; op_reg = r ^ 5'h1F;
      rf_value = ~rf; pend_valid = 1'b0;
      @(negedge clk);
    end
    op_valid = 1'b0;
    g_done = 1'b0;
    for (int i = 0; i < 60 && !g_done; i++) begin
      if (done) begin
        g_done = 1'b1; g_ldv = ld_valid; g_reg = ld_reg; g_val = ld_value;
      end else @(negedge clk);
    end
    d_rd = rd_cnt - r0; d_wr = wr_cnt - w0;
    check("R7 done seen", {31'b0, g_done}, 32'd1);
  endtask

  task automatic run_and_check(input logic [1:0] k, input logic [31:0] a, input logic [4:0] r,
                               input logic [31:0] rf, input logic pv, input logic [4:0] pr,
                               input logic [31:0] pval, input logic [31:0] m, input logic intrude);
    logic [31:0] old;
    string tag;
    do_op(k, a, r, rf, pv, pr, pval, m, intrude);
    check("R1 read address aligned", rd_addr, {a[31:2], 2'b00});
    check("R7 one read", d_rd, 32'd1);
    if (!k[1]) begin
      old = (pv && pr == r) ? pval : rf;
      tag = k[0] ? "R3 load-right value" : "R2 load-left value";
      check("R7 load writes nothing", d_wr, 32'd0);
      check("R8 ld_valid", {31'b0, g_ldv}, {31'b0, r != 5'd0});
      if (r != 5'd0) begin
        check(tag, g_val, ref_merge(k, a[1:0], m, old));
        check("R8 ld_reg", {27'b0, g_reg}, {27'b0, r});
      end
    end else begin
      tag = k[0] ? "R5 store-right data" : "R4 store-left data";
      check("R7 one write", d_wr, 32'd1);
      check("R1 write address", wr_addr, {a[31:2], 2'b00});
      check(tag, wr_data, ref_merge(k, a[1:0], m, rf));
      check("R8 no ld_valid on store", {31'b0, g_ldv}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy after reset", {31'b0, busy}, 32'd0);
    check("R10 mem_req after reset", {31'b0, mem_req}, 32'd0);
    check("R10 done/ld_valid after reset", {30'b0, done, ld_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 4; o++)
        run_and_check(k[1:0], 32'h8000_1230 + o, 5'd9, 32'hAABBCCDD,
                      1'b0, 5'd0, 32'h0, 32'h11223344, 1'b0);

    // R6: pending slot for the same register wins for a load
    run_and_check(2'b00, 32'h0000_0101, 5'd7, 32'hAABBCCDD, 1'b1, 5'd7, 32'h55667788,
                  32'h11223344, 1'b0);
    check("R6 forwarded old value", g_val, 32'h3344_7788);
    run_and_check(2'b01, 32'h0000_0103, 5'd7, 32'hAABBCCDD, 1'b1, 5'd6, 32'h55667788,
                  32'h11223344, 1'b0);
    check("R6 other register not forwarded", g_val, 32'hAABBCC11);
    run_and_check(2'b11, 32'h0000_0102, 5'd7, 32'hAABBCCDD, 1'b1, 5'd7, 32'h55667788,
                  32'h11223344, 1'b0);
    check("R6 store ignores pending slot", wr_data, 32'hCCDD3344);

    // R8: load to register 0 completes without a result
    run_and_check(2'b00, 32'h0000_0200, 5'd0, 32'hAABBCCDD, 1'b0, 5'd0, 32'h0,
                  32'h11223344, 1'b0);

    // R9: strobe during busy has no effect
    run_and_check(2'b10, 32'h0000_0301, 5'd4, 32'hAABBCCDD, 1'b0, 5'd0, 32'h0,
                  32'h11223344, 1'b1);
    check("R9 first store unaffected", wr_data, 32'h1122AABB);
    begin
      int r0;
      int reqs;
      r0 = rd_cnt; reqs = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (mem_req) reqs++;
      end
      check("R9 no request from ignored strobe", reqs, 32'd0);
      check("R9 no extra read", rd_cnt - r0, 32'd0);
    end
    run_and_check(2'b01, 32'h0000_0402, 5'd3, 32'h01020304, 1'b0, 5'd0, 32'h0,
                  32'hA0B0C0D0, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [4:0] rr;
      rr = 5'($urandom_range(0, 31));
      run_and_check(2'($urandom), $urandom, rr, $urandom, 1'($urandom),
                    ($urandom_range(0, 1) != 0) ? rr : 5'($urandom), $urandom, $urandom,
                    ($urandom_range(0, 7) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule